// File: doc/BRIEF.md
# Clickless Ramped Volume Attenuator

This block scales a stereo stream of 24-bit two's-complement samples by one linear gain word per channel. A strobe presents each sample pair. Each channel holds a stored 14-bit unsigned target gain, and a load pulse writes both targets at once. The gain actually applied does not jump to a new target. Its upper ten bits move one step per sample toward the target, while its lower four bits follow the target at the next sample. A large change of volume therefore becomes a slow slope and does not produce an audible click.

Muting is handled the same way. While either the hardware mute input or the software mute input is high, both channels use an effective target of zero, so their gains slope down to silence. When mute is released, the gains slope back up to the stored targets, which mute never overwrites. Each channel has a small ramp state machine with four states:
- G_HOLD: the upper gain bits equal the target and the target is not zero.
- G_RISE: the upper gain bits are below the target.
- G_FALL: the upper gain bits are above the target.
- G_ZERO: both the gain and the target are zero.

At every sample strobe the machine takes these transitions:
- From G_RISE, the upper bits step up by one.
- From G_FALL, the upper bits step down by one.
- From G_HOLD or G_ZERO, the upper bits stay as they are.
- Whatever the step, the state becomes the relation of the new gain to the target, so a machine that reaches the target moves to G_HOLD or G_ZERO.

The registered state then forces an exact zero at the output while the channel sits in G_ZERO. A scaled pair leaves the block two clock cycles after its strobe.

Top module: `vol_ramp_top`

## Requirements
- R1: After reset both applied gains and both stored targets are 0x3FFF (unity), out_valid is low and both outputs are zero; a sample of 16384 then returns 16383.
- R2: Each output equals floor(sample * gain / 16384), saturated to the signed 24-bit range. The gain is the one that the sample's own strobe produced. out_valid is high for exactly one cycle, two clock cycles after the strobe.
- R3: When the applied gain is zero, the output is exactly zero for any input sample, including the most negative one.
- R4: Gain bits [3:0] take the value of the effective target's bits [3:0] at the first strobe after the target changes, with no ramping.
- R5: At each strobe, gain bits [13:4] move by exactly one toward the effective target's bits [13:4]. They never pass the target and stay put once equal. Without a strobe the gain does not change.
- R6: A target load takes effect from the first strobe in a later cycle; a strobe in the same cycle as the load still uses the previous target.
- R7: When mute_hw OR mute_sw is high, both channels use an effective target of zero. Starting from unity, the gain therefore reaches zero after exactly 1023 strobes.
- R8: Releasing mute ramps each gain back to its stored target, including a target loaded while muted; muting never alters the stored targets.
- R9: The left and right channels ramp independently, each toward its own target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one cycle per frame |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| tgt_load | input | 1 | Writes both target gain words |
| tgt_left | input | 14 | Left target gain, 0x3FFF is unity |
| tgt_right | input | 14 | Right target gain, 0x3FFF is unity |
| mute_hw | input | 1 | Hardware mute request |
| mute_sw | input | 1 | Software mute request |
| out_valid | output | 1 | Scaled pair valid |
| left_out | output | 24 | Scaled left sample |
| right_out | output | 24 | Scaled right sample |

## Verification
The assertions check four rules on every cycle:
- The upper gain bits never move by more than one step.
- The gain is frozen between strobes.
- A muted channel with a nonzero gain steps down by exactly one.
- A zero gain yields a zero output, and out_valid follows each strobe by exactly two cycles.

Only the bench scenarios can show the rest:
- The exact arithmetic, including floor rounding of negative products and the full-scale values.
- That a ramp lands exactly on its target without overshoot.
- The 1023-strobe mute length.
- That a target loaded while muted is restored, and that a load in the same cycle as a strobe still uses the old target.

// File: rtl/vol_pkg.sv
package vol_pkg;
    // Relation between a channel's coarse gain bits and its effective target
    typedef enum logic [1:0] {
        G_HOLD = 2'd0,
        G_RISE = 2'd1,
        G_FALL = 2'd2,
        G_ZERO = 2'd3
    } ramp_state_e;
endpackage

// File: rtl/vol_gain_ramp.sv
module vol_gain_ramp
    import vol_pkg::*;
#(
    parameter int GAIN_W = 14,
    parameter int FAST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [GAIN_W-1:0] target,
    output logic [GAIN_W-1:0] gain_q,
    output logic              at_zero
);
    localparam int SLOW_W = GAIN_W - FAST_W;

    ramp_state_e state_q;
    ramp_state_e dir_now;
    ramp_state_e state_after;
    logic [SLOW_W-1:0] cur_hi;
    logic [SLOW_W-1:0] tgt_hi;
    logic [SLOW_W-1:0] hi_next;

    assign cur_hi = gain_q[GAIN_W-1:FAST_W];
    assign tgt_hi = target[GAIN_W-1:FAST_W];

    // Direction for the coming step, from the present gain and target
    always_comb begin
        if (cur_hi < tgt_hi)
            dir_now = G_RISE;
        else if (cur_hi > tgt_hi)
            dir_now = G_FALL;
        else if ((cur_hi == '0) && (target == '0))
            dir_now = G_ZERO;
        else
            dir_now = G_HOLD;
    end

    // Coarse step and the state reached after it
    always_comb begin
        hi_next = cur_hi;
        unique case (dir_now)
            G_RISE:         hi_next = cur_hi + 1'b1;
            G_FALL:         hi_next = cur_hi - 1'b1;
            G_HOLD, G_ZERO: hi_next = cur_hi;
        endcase
        if (hi_next < tgt_hi)
            state_after = G_RISE;
        else if (hi_next > tgt_hi)
            state_after = G_FALL;
        else if ((hi_next == '0) && (target == '0))
            state_after = G_ZERO;
        else
            state_after = G_HOLD;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= G_HOLD;
        else if (step_en)
            state_q <= state_after;
    end

    // Gain register: coarse bits slew, fine bits follow the target
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gain_q <= '1;
        else if (step_en)
            gain_q <= {hi_next, target[FAST_W-1:0]};
    end

    assign at_zero = (state_q == G_ZERO);
endmodule

// File: rtl/vol_scaler.sv
module vol_scaler #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 14
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [GAIN_W-1:0]   gain,
    input  logic                force_zero,
    output logic [SAMPLE_W-1:0] scaled
);
    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] g_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic signed [PROD_W-1:0] max_v;
    logic signed [PROD_W-1:0] min_v;

    assign s_ext   = {{(GAIN_W+1){sample[SAMPLE_W-1]}}, sample};
    assign g_ext   = {{(SAMPLE_W+1){1'b0}}, gain};
    assign prod    = s_ext * g_ext;
    assign shifted = prod >>> GAIN_W;
    assign max_v   = {{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    assign min_v   = ~max_v;

    always_comb begin
        if (force_zero)
            scaled = '0;
        else if (shifted > max_v)
            scaled = max_v[SAMPLE_W-1:0];
        else if (shifted < min_v)
            scaled = min_v[SAMPLE_W-1:0];
        else
            scaled = shifted[SAMPLE_W-1:0];
    end
endmodule

// File: rtl/vol_ramp_top.sv
module vol_ramp_top #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 14,
    parameter int FAST_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                tgt_load,
    input  logic [GAIN_W-1:0]   tgt_left,
    input  logic [GAIN_W-1:0]   tgt_right,
    input  logic                mute_hw,
    input  logic                mute_sw,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out
);
    localparam int NCH = 2;

    logic [GAIN_W-1:0]   tgt_in   [NCH];
    logic [GAIN_W-1:0]   stored_q [NCH];
    logic [GAIN_W-1:0]   eff_tgt  [NCH];
    logic [GAIN_W-1:0]   gain_q   [NCH];
    logic                zero_st  [NCH];
    logic [SAMPLE_W-1:0] smp_in   [NCH];
    logic [SAMPLE_W-1:0] smp_q    [NCH];
    logic [SAMPLE_W-1:0] scaled   [NCH];
    logic [SAMPLE_W-1:0] out_q    [NCH];
    logic                mute_eff;
    logic                s1_valid;
    logic [GAIN_W-1:0]   gain_l;
    logic [GAIN_W-1:0]   gain_r;

    assign tgt_in[0] = tgt_left;
    assign tgt_in[1] = tgt_right;
    assign smp_in[0] = left_in;
    assign smp_in[1] = right_in;
    assign mute_eff  = mute_hw | mute_sw;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stored_q[ch] <= '1;
            else if (tgt_load)
                stored_q[ch] <= tgt_in[ch];
        end

        assign eff_tgt[ch] = mute_eff ? '0 : stored_q[ch];

        vol_gain_ramp #(
            .GAIN_W (GAIN_W),
            .FAST_W (FAST_W)
        ) u_ramp (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (smp_valid),
            .target  (eff_tgt[ch]),
            .gain_q  (gain_q[ch]),
            .at_zero (zero_st[ch])
        );

        vol_scaler #(
            .SAMPLE_W (SAMPLE_W),
            .GAIN_W   (GAIN_W)
        ) u_scale (
            .sample     (smp_q[ch]),
            .gain       (gain_q[ch]),
            .force_zero (zero_st[ch]),
            .scaled     (scaled[ch])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                smp_q[ch] <= '0;
                out_q[ch] <= '0;
            end else begin
                if (smp_valid)
                    smp_q[ch] <= smp_in[ch];
                if (s1_valid)
                    out_q[ch] <= scaled[ch];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= smp_valid;
            out_valid <= s1_valid;
        end
    end

    assign left_out  = out_q[0];
    assign right_out = out_q[1];
    assign gain_l    = gain_q[0];
    assign gain_r    = gain_q[1];
endmodule

// File: rtl/vol_ramp_chk.sv
module vol_ramp_chk #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 14,
    parameter int FAST_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic                mute_hw,
    input logic                mute_sw,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input logic [GAIN_W-1:0]   gain_l,
    input logic [GAIN_W-1:0]   gain_r
);
    logic [GAIN_W-FAST_W-1:0] hi_l;
    logic [GAIN_W-FAST_W-1:0] hi_r;
    assign hi_l = gain_l[GAIN_W-1:FAST_W];
    assign hi_r = gain_r[GAIN_W-1:FAST_W];

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_l == $past(hi_l)) || (hi_l == $past(hi_l) + 1'b1) || (hi_l == $past(hi_l) - 1'b1));

    // R5
    single_step_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_r == $past(hi_r)) || (hi_r == $past(hi_r) + 1'b1) || (hi_r == $past(hi_r) - 1'b1));

    // R5
    frozen_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(gain_l) && $stable(gain_r)));

    // R7
    mute_descent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mute_hw || mute_sw) && smp_valid && (hi_l != '0))
        |=> ((hi_l == $past(hi_l) - 1'b1) && (gain_l[FAST_W-1:0] == '0)));

    // R3
    zero_gain_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(gain_l) == '0)) |-> (left_out == '0));

    // R3
    zero_gain_out_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(gain_r) == '0)) |-> (right_out == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> ##1 out_valid);

    // R2
    valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(smp_valid, 2));
endmodule

bind vol_ramp_top vol_ramp_chk #(
    .SAMPLE_W (SAMPLE_W),
    .GAIN_W   (GAIN_W),
    .FAST_W   (FAST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .mute_hw   (mute_hw),
    .mute_sw   (mute_sw),
    .out_valid (out_valid),
    .left_out  (left_out),
    .right_out (right_out),
    .gain_l    (gain_l),
    .gain_r    (gain_r)
);

// File: tb/sim_vol_ramp_top.sv
`timescale 1ns/1ps
module sim_vol_ramp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] left_in = '0;
    logic [23:0] right_in = '0;
    logic        tgt_load = 1'b0;
    logic [13:0] tgt_left = '0;
    logic [13:0] tgt_right = '0;
    logic        mute_hw = 1'b0;
    logic        mute_sw = 1'b0;
    logic        out_valid;
    logic [23:0] left_out;
    logic [23:0] right_out;

    int checks = 0;
    int errors = 0;
    longint got_l;
    longint got_r;

    always #4 clk = ~clk;

    vol_ramp_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .left_in   (left_in),
        .right_in  (right_in),
        .tgt_load  (tgt_load),
        .tgt_left  (tgt_left),
        .tgt_right (tgt_right),
        .mute_hw   (mute_hw),
        .mute_sw   (mute_sw),
        .out_valid (out_valid),
        .left_out  (left_out),
        .right_out (right_out)
    );

    function automatic longint scl(input longint x, input longint g);
        longint p;
        p = (x * g) >>> 14;
        if (p > 8388607) p = 8388607;
        if (p < -8388608) p = -8388608;
        return p;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_valid = 1'b0; tgt_load = 1'b0; mute_hw = 1'b0; mute_sw = 1'b0;
        left_in = '0; right_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe(input longint l, input longint r);
        @(negedge clk);
        smp_valid = 1'b1;
        left_in = l[23:0];
        right_in = r[23:0];
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        got_l = longint'($signed(left_out));
        got_r = longint'($signed(right_out));
    endtask

    task automatic load(input logic [13:0] l, input logic [13:0] r);
        @(negedge clk);
        tgt_load = 1'b1; tgt_left = l; tgt_right = r;
        @(negedge clk);
        tgt_load = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 out_valid after reset", longint'(out_valid), 0);
        chk("R1 left_out after reset", longint'($signed(left_out)), 0);
        chk("R1 right_out after reset", longint'($signed(right_out)), 0);
        strobe(16384, -16384);
        chk("R1 unity gain left", got_l, 16383);
        chk("R1 unity gain right", got_r, -16383);
        chk("R2 out_valid two cycles after strobe", longint'(out_valid), 1);
        @(negedge clk);
        chk("R2 out_valid single cycle", longint'(out_valid), 0);
    endtask

    task automatic t_scale();
        do_reset();
        strobe(8388607, -8388608);
        chk("R2 positive full scale", got_l, scl(8388607, 16383));
        chk("R2 negative full scale", got_r, scl(-8388608, 16383));
        strobe(-1, 12345);
        chk("R2 floor of -1", got_l, -1);
        chk("R2 mid value", got_r, scl(12345, 16383));
    endtask

    task automatic t_lowbits();
        do_reset();
        load(14'h3FF0, 14'h3FF7);
        strobe(16384, 16384);
        chk("R4 fine bits left immediate", got_l, 16368);
        chk("R4 fine bits right immediate", got_r, 16375);
    endtask

    task automatic t_ramp();
        longint e;
        do_reset();
        load(14'h3F05, 14'h3FFF);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            strobe(16384, 16384);
            e = ((1023 - k) > 1008 ? (1023 - k) : 1008) * 16 + 5;
            chk("R5 ramp down left", got_l, e);
            chk("R9 right untouched", got_r, 16383);
        end
        load(14'h3FFF, 14'h3FFF);
        for (int k = 1; k <= 20; k++) begin
            strobe(16384, -16384);
            e = ((1008 + k) < 1023 ? (1008 + k) : 1023) * 16 + 15;
            chk("R5 ramp up left", got_l, e);
            chk("R9 right unity", got_r, -16383);
        end
    endtask

    task automatic t_timing();
        do_reset();
        @(negedge clk);
        tgt_load = 1'b1; tgt_left = 14'h3FF0; tgt_right = 14'h3FF0;
        smp_valid = 1'b1; left_in = 24'd16384; right_in = 24'd16384;
        @(negedge clk);
        tgt_load = 1'b0; smp_valid = 1'b0;
        @(negedge clk);
        chk("R6 same-cycle load uses old target", longint'($signed(left_out)), 16383);
        strobe(16384, 16384);
        chk("R6 later strobe uses new target", got_l, 16368);
    endtask

    task automatic t_hwmute();
        do_reset();
        mute_hw = 1'b1;
        for (int k = 1; k <= 1023; k++) begin
            strobe(16384, -16384);
            chk("R7 mute ramp left", got_l, (1023 - k) * 16);
            chk("R7 mute ramp right", got_r, -(1023 - k) * 16);
        end
        strobe(-8388608, 8388607);
        chk("R3 zero gain left", got_l, 0);
        chk("R3 zero gain right", got_r, 0);
        mute_hw = 1'b0;
        for (int k = 1; k <= 1023; k++) begin
            strobe(16384, 16384);
            chk("R8 unmute ramp left", got_l, k * 16 + 15);
        end
        strobe(16384, 16384);
        chk("R5 stops at target", got_l, 16383);
        chk("R8 right restored", got_r, 16383);
    endtask

    task automatic t_swmute();
        do_reset();
        mute_sw = 1'b1;
        for (int k = 1; k <= 1023; k++) strobe(16384, 16384);
        chk("R7 soft mute left zero", got_l, 0);
        chk("R7 soft mute right zero", got_r, 0);
        load(14'h2005, 14'h100A);
        strobe(16384, 16384);
        chk("R8 load while muted stays silent", got_l, 0);
        mute_sw = 1'b0;
        for (int k = 1; k <= 520; k++) begin
            strobe(16384, 16384);
            chk("R8 restore left", got_l, ((k < 512) ? k : 512) * 16 + 5);
            chk("R9 restore right", got_r, ((k < 256) ? k : 256) * 16 + 10);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_scale();
        t_lowbits();
        t_ramp();
        t_timing();
        t_hwmute();
        t_swmute();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule